// File: doc/BRIEF.md
# Quad-Rate Burst SRAM Port Model

This block is a synthesizable behavioural model of a static memory that has a read port and a write port working side by side. Each port moves four data words for every address it accepts. Data moves on both halves of the memory clock. The model is meant to be the device under a memory-controller testbench. It runs from one clock, `clk_2x`, at twice the memory clock rate. An internal phase flag marks every other edge as the memory clock's rising edge, called the "K rise". The edge between two K rises is the "complementary rise". The first edge after reset is released is a K rise.

The address on each port names a burst of four consecutive words. The word address is the burst address with two beat bits appended below it. A write takes its four data words, each with its own lane enables, over the two memory cycles that follow the request. A read snapshots its four words when it is accepted. It returns them on the four half-cycle beats that start two memory cycles later. A valid flag marks exactly those beats. A port that has just accepted a request ignores its select on the next K rise, so bursts on one port never overlap.

Top module: `qdr_burst_sram`

## Requirements
- R1: A write request is accepted when `wr_sel_n` is low at a K rise, and `wr_addr` is captured as the burst address on that same edge.
- R2: A read request is accepted when `rd_sel_n` is low at a K rise. A select that is low only at a complementary rise starts nothing on either port.
- R3: A request at burst address A covers the four words A*4+0 to A*4+3, with beat n going to or coming from word A*4+n.
- R4: Write beat 0 is taken from `wr_data`/`wr_lane_n` at the K rise one memory cycle after the request. Beats 1, 2 and 3 are taken on the three edges that follow.
- R5: Read beat 0 appears on `rd_data` at the K rise two memory cycles after the request. Beats 1, 2 and 3 follow on the next three edges. `rd_valid` is high for exactly those four beats.
- R6: `wr_lane_n[i]` controls bits [4i+3:4i] of each beat on its own. A low bit writes that lane for that beat, and a high bit leaves that lane of the stored word unchanged.
- R7: A read and a write may be accepted on the same K rise, at different addresses, without affecting each other.
- R8: A read accepted on the same K rise as a write to the same burst returns the four words as they were before that write.
- R9: On the K rise right after a port accepts a request, that port ignores its select and address.
- R10: With both selects high, no word is written, whatever `wr_data` and `wr_lane_n` carry. `rd_data` is zero whenever `rd_valid` is low.
- R11: A synchronous active-high `rst` clears both request pipelines and `rd_valid`, aborting any pending read. The stored array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Clock at twice the memory clock rate; every edge is one data beat |
| rst | input | 1 | Synchronous active-high reset of the pipelines |
| wr_sel_n | input | 1 | Active-low write request, sampled at K rises |
| wr_addr | input | ADDR_W | Burst address of a write request |
| wr_data | input | DATA_W | Write beat data |
| wr_lane_n | input | DATA_W/LANE_W | Active-low lane write enables for the current write beat |
| rd_sel_n | input | 1 | Active-low read request, sampled at K rises |
| rd_addr | input | ADDR_W | Burst address of a read request |
| rd_data | output | DATA_W | Read beat data, zero when not valid |
| rd_valid | output | 1 | High on each beat that carries read data |

## Verification
The bench builds the block with its defaults: 4-bit burst addresses (sixteen bursts, sixty-four words), 8-bit data split into two 4-bit lanes, and zeroed idle read data. Sixteen bursts are few enough to fill and read back the whole array, including the top burst, in a few hundred cycles. Two lanes are enough to show a per-beat mix of written and kept nibbles. The zero-idle setting lets every non-valid beat be checked against zero.

// File: rtl/qdr_pkg.sv
`timescale 1ns/1ps
package qdr_pkg;
   localparam int BURST_LEN = 4;
   localparam int BEAT_W    = 2;
   typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/qdr_mem_array.sv
`timescale 1ns/1ps
module qdr_mem_array
   import qdr_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int LANE_W = 4
) (
   input  logic                       clk,
   input  logic                       wr_en,
   input  logic [ADDR_W+BEAT_W-1:0]   wr_word,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [DATA_W/LANE_W-1:0]   wr_lane_n,
   input  logic [ADDR_W-1:0]          rd_burst,
   output logic [BURST_LEN*DATA_W-1:0] rd_words
);
   localparam int LANES = DATA_W / LANE_W;
   localparam int WORDS = BURST_LEN * (1 << ADDR_W);

   logic [DATA_W-1:0] mem [WORDS];

   // per-lane masked write, one word per edge
   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int l = 0; l < LANES; l++) begin
            if (!wr_lane_n[l])
               mem[wr_word][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
         end
      end
   end

   // whole-burst read, all beats at once
   for (genvar b = 0; b < BURST_LEN; b++) begin : g_rd_beat
      assign rd_words[b*DATA_W +: DATA_W] = mem[{rd_burst, beat_t'(b)}];
   end
endmodule

// File: rtl/qdr_wr_seq.sv
`timescale 1ns/1ps
module qdr_wr_seq
   import qdr_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int LANES  = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     k_rise,
   input  logic                     sel_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [LANES-1:0]         lane_n,
   output logic                     mem_we,
   output logic [ADDR_W+BEAT_W-1:0] mem_word,
   output logic [LANES-1:0]         mem_lane_n
);
   logic              pend_q, act_q;
   logic [ADDR_W-1:0] pend_addr_q, act_addr_q;
   beat_t             beat_q;
   logic              accept, start;

   assign accept     = k_rise && !sel_n && !pend_q;
   assign start      = k_rise && pend_q;
   assign mem_we     = start || act_q;
   assign mem_word   = start ? {pend_addr_q, beat_t'(0)} : {act_addr_q, beat_q};
   assign mem_lane_n = lane_n;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q      <= 1'b0;
         act_q       <= 1'b0;
         beat_q      <= '0;
         pend_addr_q <= '0;
         act_addr_q  <= '0;
      end else begin
         if (start) begin
            act_q      <= 1'b1;
            act_addr_q <= pend_addr_q;
            beat_q     <= beat_t'(1);
         end else if (act_q) begin
            beat_q <= beat_q + beat_t'(1);
            if (beat_q == beat_t'(BURST_LEN-1)) act_q <= 1'b0;
         end
         if (accept) begin
            pend_q      <= 1'b1;
            pend_addr_q <= addr;
         end else if (start) begin
            pend_q <= 1'b0;
         end
      end
   end

   AST_WR_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
      !(k_rise && pend_q && act_q)); // R9
   AST_WR_FROM_PEND: assert property (@(posedge clk) disable iff (rst)
      $rose(act_q) |-> $past(pend_q)); // R4
endmodule

// File: rtl/qdr_rd_seq.sv
`timescale 1ns/1ps
module qdr_rd_seq
   import qdr_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        k_rise,
   input  logic                        sel_n,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [BURST_LEN*DATA_W-1:0] burst_words,
   output logic [ADDR_W-1:0]           burst_sel,
   output logic [DATA_W-1:0]           q,
   output logic                        q_valid
);
   localparam int SH_W = (BURST_LEN-1) * DATA_W;

   logic                        s1_vld_q, s1_age_q;
   logic [BURST_LEN*DATA_W-1:0] s1_data_q;
   logic [SH_W-1:0]             sh_q;
   beat_t                       left_q;
   logic [DATA_W-1:0]           q_q;
   logic                        vld_q;
   logic                        accept, xfer;

   assign burst_sel = addr;
   assign accept    = k_rise && !sel_n && !(s1_vld_q && !s1_age_q);
   assign xfer      = k_rise && s1_vld_q && s1_age_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld_q  <= 1'b0;
         s1_age_q  <= 1'b0;
         s1_data_q <= '0;
         sh_q      <= '0;
         left_q    <= '0;
         q_q       <= '0;
         vld_q     <= 1'b0;
      end else begin
         if (accept) begin
            s1_vld_q  <= 1'b1;
            s1_age_q  <= 1'b0;
            s1_data_q <= burst_words;
         end else if (k_rise && s1_vld_q) begin
            s1_age_q <= 1'b1;
            if (s1_age_q) s1_vld_q <= 1'b0;
         end
         if (xfer) begin
            q_q    <= s1_data_q[DATA_W-1:0];
            sh_q   <= s1_data_q[BURST_LEN*DATA_W-1:DATA_W];
            left_q <= beat_t'(BURST_LEN-1);
            vld_q  <= 1'b1;
         end else if (left_q != '0) begin
            q_q    <= sh_q[DATA_W-1:0];
            sh_q   <= sh_q >> DATA_W;
            left_q <= left_q - beat_t'(1);
            vld_q  <= 1'b1;
         end else begin
            vld_q <= 1'b0;
         end
      end
   end

   assign q_valid = vld_q;

   if (IDLE_ZERO) begin : g_idle_zero
      assign q = vld_q ? q_q : '0;
   end else begin : g_idle_hold
      assign q = q_q;
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
         (!vld_q && $past(!vld_q)) |-> $stable(q)); // R10
   end

   AST_XFER_EMPTY: assert property (@(posedge clk) disable iff (rst)
      xfer |-> (left_q == '0)); // R5
   AST_VALID_RUN: assert property (@(posedge clk) disable iff (rst)
      $rose(vld_q) |=> vld_q); // R5
endmodule

// File: rtl/qdr_burst_sram.sv
`timescale 1ns/1ps
module qdr_burst_sram
   import qdr_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int LANE_W    = 4,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic                       clk_2x,
   input  logic                       rst,
   input  logic                       wr_sel_n,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [DATA_W/LANE_W-1:0]   wr_lane_n,
   input  logic                       rd_sel_n,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       rd_valid
);
   localparam int LANES = DATA_W / LANE_W;

   if (ADDR_W < 1) begin : g_bad_addr
      $error("qdr_burst_sram: ADDR_W must be at least 1");
   end
   if (LANE_W < 1 || DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("qdr_burst_sram: DATA_W must be a multiple of LANE_W");
   end

   // high when the coming edge is a K rise
   logic k_rise_q;
   always_ff @(posedge clk_2x) begin
      if (rst) k_rise_q <= 1'b1;
      else     k_rise_q <= ~k_rise_q;
   end

   logic                        mem_we;
   logic [ADDR_W+BEAT_W-1:0]    mem_word;
   logic [LANES-1:0]            mem_lane_n;
   logic [ADDR_W-1:0]           rd_burst;
   logic [BURST_LEN*DATA_W-1:0] rd_words;

   qdr_wr_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wr (
      .clk(clk_2x), .rst(rst), .k_rise(k_rise_q),
      .sel_n(wr_sel_n), .addr(wr_addr), .lane_n(wr_lane_n),
      .mem_we(mem_we), .mem_word(mem_word), .mem_lane_n(mem_lane_n)
   );

   qdr_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_mem (
      .clk(clk_2x), .wr_en(mem_we), .wr_word(mem_word), .wr_data(wr_data),
      .wr_lane_n(mem_lane_n), .rd_burst(rd_burst), .rd_words(rd_words)
   );

   qdr_rd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDLE_ZERO(IDLE_ZERO)) u_rd (
      .clk(clk_2x), .rst(rst), .k_rise(k_rise_q),
      .sel_n(rd_sel_n), .addr(rd_addr), .burst_words(rd_words),
      .burst_sel(rd_burst), .q(rd_data), .q_valid(rd_valid)
   );

   AST_VALID_ON_K: assert property (@(posedge clk_2x) disable iff (rst)
      $rose(rd_valid) |-> !k_rise_q); // R5
endmodule

// File: tb/tb_qdr_burst_sram.sv
`timescale 1ns/1ps
module tb_qdr_burst_sram;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int LW = 4;
   localparam int LN = DW / LW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_sel_n = 1'b1;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [LN-1:0] wr_lane_n = '1;
   logic          rd_sel_n = 1'b1;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          rd_valid;

   int n_cmp = 0;
   int n_bad = 0;
   int ecnt  = 0;
   bit done  = 1'b0;
   logic [DW-1:0] model [64];

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      if (rst) ecnt <= 0;
      else     ecnt <= ecnt + 1;
   end

   qdr_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(LW), .IDLE_ZERO(1'b1)) dut (
      .clk_2x(clk), .rst(rst), .wr_sel_n(wr_sel_n), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_lane_n(wr_lane_n), .rd_sel_n(rd_sel_n),
      .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // stop at a negedge whose following posedge is a K rise
   task automatic align_k();
      @(negedge clk);
      while (ecnt % 2 != 0) @(negedge clk);
   endtask

   // one scenario window of ten beats; step s drives for edge e+s
   task automatic run_burst(input string tag,
                            input bit rd_en, input logic [AW-1:0] ra, input bit rd_hold,
                            input bit wr_en, input logic [AW-1:0] wa, input bit wr_hold,
                            input logic [AW-1:0] wa_alt, input bit comp_only,
                            input logic [4*DW-1:0] wd, input logic [4*LN-1:0] lane_n);
      logic [DW-1:0] exp_w [4];
      bit rd_go, wr_go, lo;
      align_k();
      rd_go = rd_en && !comp_only;
      wr_go = wr_en && !comp_only;
      // read snapshot precedes this window's write (R8)
      for (int j = 0; j < 4; j++) exp_w[j] = model[{ra, 2'(j)}];
      if (wr_go) begin
         for (int j = 0; j < 4; j++)
            for (int l = 0; l < LN; l++)
               if (!lane_n[j*LN + l])
                  model[{wa, 2'(j)}][l*LW +: LW] = wd[j*DW + l*LW +: LW];
      end
      for (int s = 0; s < 10; s++) begin
         if (s > 0) begin
            @(negedge clk);
            if (rd_go && s >= 5 && s <= 8) begin
               chk("R5", {tag, " valid"}, 32'(rd_valid), 32'd1);
               chk(tag, $sformatf("beat %0d", s - 5), 32'(rd_data), 32'(exp_w[s-5]));
            end else begin
               chk("R5", {tag, " idle valid"}, 32'(rd_valid), 32'd0);
               chk("R10", {tag, " idle data"}, 32'(rd_data), 32'd0);
            end
         end
         lo = comp_only ? (s == 1) : (s == 0 || (rd_hold && s <= 2));
         rd_sel_n = !(rd_en && lo);
         rd_addr  = (s == 0) ? ra : ~ra;
         lo = comp_only ? (s == 1) : (s == 0 || (wr_hold && s <= 2));
         wr_sel_n = !(wr_en && lo);
         wr_addr  = (s == 0) ? wa : wa_alt;
         if (s >= 2 && s <= 5) begin
            wr_data   = wd[(s-2)*DW +: DW];
            wr_lane_n = lane_n[(s-2)*LN +: LN];
         end else begin
            wr_data   = 8'h5A;
            wr_lane_n = '0;
         end
      end
      wr_lane_n = '1;
   endtask

   task automatic rd_only(input string tag, input logic [AW-1:0] ra);
      run_burst(tag, 1'b1, ra, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0, '1);
   endtask

   task automatic wr_only(input logic [AW-1:0] wa, input logic [4*DW-1:0] wd,
                          input logic [4*LN-1:0] lane_n);
      run_burst("R1 R4", 1'b0, '0, 1'b0, 1'b1, wa, 1'b0, wa, 1'b0, wd, lane_n);
   endtask

   task automatic t_reset_state();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11", "valid in reset", 32'(rd_valid), 32'd0);
      chk("R11", "data in reset", 32'(rd_data), 32'd0);
      rst = 1'b0;
   endtask

   task automatic t_fill_and_read();
      for (int a = 0; a < 16; a++)
         wr_only(AW'(a), {8'(a*16+3), 8'(a*16+2), 8'(a*16+1), 8'(a*16)}, '0);
      for (int a = 0; a < 16; a++) rd_only("R2 R3", AW'(a));
   endtask

   task automatic t_lanes();
      // beat0 writes lane1, beat1 writes lane0, beat2 none, beat3 both
      wr_only(4'd3, 32'hE4_D3_C2_B1, {2'b00, 2'b11, 2'b10, 2'b01});
      rd_only("R6", 4'd3);
   endtask

   task automatic t_concurrent();
      run_burst("R7", 1'b1, 4'd3, 1'b0, 1'b1, 4'd5, 1'b0, 4'd5, 1'b0,
                32'h77_66_55_44, '0);
      rd_only("R7", 4'd5);
   endtask

   task automatic t_same_burst();
      run_burst("R8", 1'b1, 4'd6, 1'b0, 1'b1, 4'd6, 1'b0, 4'd6, 1'b0,
                32'hAD_AC_AB_AA, '0);
      rd_only("R8", 4'd6);
   endtask

   task automatic t_busy();
      run_burst("R9", 1'b1, 4'd9, 1'b1, 1'b1, 4'd9, 1'b1, 4'd10, 1'b0,
                32'h9D_9C_9B_9A, '0);
      rd_only("R9", 4'd10);
      rd_only("R9", 4'd9);
   endtask

   task automatic t_deselect();
      run_burst("R10", 1'b0, '0, 1'b0, 1'b0, 4'd2, 1'b0, 4'd2, 1'b0,
                32'hFF_EE_DD_CC, '0);
      rd_only("R10", 4'd2);
      // selects low only on the complementary rise
      run_burst("R2", 1'b1, 4'd4, 1'b0, 1'b1, 4'd4, 1'b0, 4'd4, 1'b1,
                32'h13_12_11_10, '0);
      rd_only("R2", 4'd4);
   endtask

   task automatic t_reset_abort();
      align_k();
      rd_sel_n = 1'b0; rd_addr = 4'd15;
      @(negedge clk); rd_sel_n = 1'b1;
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      @(negedge clk); rst = 1'b0;
      for (int s = 0; s < 8; s++) begin
         @(negedge clk);
         chk("R11", "aborted read valid", 32'(rd_valid), 32'd0);
         chk("R11", "aborted read data", 32'(rd_data), 32'd0);
      end
      rd_only("R11", 4'd15);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) model[i] = '0;
      t_reset_state();
      t_fill_and_read();
      t_lanes();
      t_concurrent();
      t_same_burst();
      t_busy();
      t_deselect();
      t_reset_abort();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule